// File: doc/BRIEF.md
# Static Memory Write Strobe Sequencer

This block times write cycles to an asynchronous static memory spread over several chip-select banks. All timing is counted in system clock cycles. Each bank has two timing registers. The strobe delay register holds the number of cycles the write strobe waits before it asserts. The wait-state register holds the number of extra cycles the strobe window lasts.

A write request carries a bank, an address, data and byte enables. It is accepted only while the sequencer is idle and external access is permitted. Once accepted, the cycle walks through four named states:

- `S_IDLE`: no cycle in progress. An accepted request moves to `S_ADDR`.
- `S_ADDR`: one set-up cycle. It always moves to `S_WAIT`.
- `S_WAIT`: the strobe window, lasting wait-state + 1 cycles. It moves to `S_HOLD` when the counter reaches the wait-state value.
- `S_HOLD`: one hold cycle. It always returns to `S_IDLE`.

The strobe delay lives inside the strobe window, so it never lengthens the cycle. The cycle is always wait-state + 3 clocks long. Chip select, address and data stay driven from `S_ADDR` through `S_HOLD`. A one-cycle done pulse marks `S_HOLD`.

A small register port reads and writes the timing registers. A write that arrives while a cycle runs is held off until the sequencer is idle again. The cycle in flight keeps the timing it captured when it was accepted.

Top module: `sws_write_seq`

## Requirements
- R1: Every accepted write keeps its chip select asserted for exactly W+3 consecutive clocks, where W is the bank's wait-state value (three clocks when W is 0).
- R2: In window cycle k (k = 0..W, the cycles after the set-up cycle), the write strobe is high exactly when k ≥ min(D, W), where D is the bank's strobe delay. A delay above W is clamped to W, so the strobe asserts for at least one cycle.
- R3: Chip select, address, data and the data-drive enable stay constant from the set-up cycle through the hold cycle. The strobe is low in the set-up cycle and in the hold cycle.
- R4: `done` is high for one clock, in the hold cycle only. `req_ready` is high only in `S_IDLE`, and chip select asserts on the clock after an accepted request.
- R5: Register map, in byte addresses: bank b occupies base 0x20·b. Offset 0x00 holds the strobe delay and offset 0x04 holds the wait-state value. Each value is 5 bits wide, in bits 4:0. Bits 31:5 read as zero. Other offsets read zero, and writes to them change nothing.
- R6: After reset, every wait-state value is 31, every strobe delay is 0, all memory outputs are inactive and `req_ready` is high.
- R7: `reg_wait` is high while a cycle is in progress and in the clock a request is accepted. A held-off register write commits once the sequencer is idle, and the cycle in flight keeps its captured timing.
- R8: While `acc_en` is low or `low_power` is high, `req_ready` is low and no request is accepted.
- R9: Chip select is one-hot: bit b is set for a request to bank b, and each bank uses its own timing registers.
- R10: The byte-lane enables equal the request's byte enables while the strobe is high, and are zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_en | input | 1 | External access enabled |
| low_power | input | 1 | Low-power mode; blocks access |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Request accepted this clock when valid |
| req_bank | input | clog2(BANKS) | Target bank |
| req_addr | input | AW | Write address |
| req_data | input | DW | Write data |
| req_be | input | DW/8 | Byte enables |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | clog2(BANKS)+5 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| reg_wait | output | 1 | Register write held off |
| mem_cs | output | BANKS | Chip selects, active high |
| mem_we | output | 1 | Write strobe, active high |
| mem_be | output | DW/8 | Byte-lane enables, active high |
| mem_addr | output | AW | Memory address |
| mem_dout | output | DW | Memory write data |
| mem_oe | output | 1 | Data bus drive enable |
| done | output | 1 | Hold-cycle completion pulse |

## Verification
The assertions assume that a requester holds `req_valid` until it sees `req_ready`. They also assume that the timing registers change only through the register port, so a write can never slip into a cycle that is already running. The assertions do not require the wait-state value to be at least the strobe delay, because the clamp covers that case.

The bench keeps within these assumptions in three ways:
- It raises each request at a falling edge and drops it on the first falling edge after acceptance.
- It issues register writes either while idle, or in the middle of a cycle with the write left pending.
- It draws random delays that often exceed the wait-state value, so the clamp path is exercised.

// File: rtl/sws_pkg.sv
package sws_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ADDR,
        S_WAIT,
        S_HOLD
    } sws_state_e;

    // byte offsets inside one bank's 0x20 register slot
    localparam logic [4:0] OFF_DLY  = 5'h00;
    localparam logic [4:0] OFF_WAIT = 5'h04;
    localparam int         SLOT_W   = 5;

endpackage

// File: rtl/sws_regs.sv
module sws_regs
    import sws_pkg::*;
#(
    parameter int BANKS = 4,
    parameter int FW    = 5,
    localparam int BK_W = $clog2(BANKS),
    localparam int RA_W = BK_W + SLOT_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [RA_W-1:0]          addr,
    input  logic [31:0]              wr_data,
    output logic [31:0]              rd_data,
    output logic [BANKS-1:0][FW-1:0] dly_o,
    output logic [BANKS-1:0][FW-1:0] wait_o
);

    logic [BK_W-1:0]   sel;
    logic [SLOT_W-1:0] off;
    logic              bank_ok;
    logic              unused_hi;

    assign sel       = addr[RA_W-1:SLOT_W];
    assign off       = addr[SLOT_W-1:0];
    assign unused_hi = ^wr_data[31:FW];

    generate
        if ((1 << BK_W) == BANKS) begin : g_full
            assign bank_ok = 1'b1;
        end else begin : g_part
            assign bank_ok = (int'(sel) < BANKS);
        end
    endgenerate

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dly_o[b]  <= '0;
                wait_o[b] <= '1;
            end else if (wr_en && bank_ok && (sel == BK_W'(b))) begin
                if (off == OFF_DLY)  dly_o[b]  <= wr_data[FW-1:0];
                if (off == OFF_WAIT) wait_o[b] <= wr_data[FW-1:0];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (bank_ok) begin
            if (off == OFF_DLY)  rd_data[FW-1:0] = dly_o[sel];
            if (off == OFF_WAIT) rd_data[FW-1:0] = wait_o[sel];
        end
    end

endmodule

// File: rtl/sws_capture.sv
module sws_capture #(
    parameter int BANKS = 4,
    parameter int AW    = 24,
    parameter int DW    = 32,
    parameter int FW    = 5,
    localparam int BW   = DW / 8,
    localparam int BK_W = $clog2(BANKS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     take,
    input  logic [BK_W-1:0]          in_bank,
    input  logic [AW-1:0]            in_addr,
    input  logic [DW-1:0]            in_data,
    input  logic [BW-1:0]            in_be,
    input  logic [BANKS-1:0][FW-1:0] dly_all,
    input  logic [BANKS-1:0][FW-1:0] wait_all,
    output logic [BK_W-1:0]          lat_bank,
    output logic [AW-1:0]            lat_addr,
    output logic [DW-1:0]            lat_data,
    output logic [BW-1:0]            lat_be,
    output logic [FW-1:0]            lat_wait,
    output logic [FW-1:0]            lat_dly
);

    logic [FW-1:0] pick_dly;
    logic [FW-1:0] pick_wait;
    logic [FW-1:0] clamped;

    assign pick_dly  = dly_all[in_bank];
    assign pick_wait = wait_all[in_bank];
    // a delay past the window end would leave the strobe silent
    assign clamped   = (pick_dly > pick_wait) ? pick_wait : pick_dly;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_bank <= '0;
            lat_addr <= '0;
            lat_data <= '0;
            lat_be   <= '0;
            lat_wait <= '0;
            lat_dly  <= '0;
        end else if (take) begin
            lat_bank <= in_bank;
            lat_addr <= in_addr;
            lat_data <= in_data;
            lat_be   <= in_be;
            lat_wait <= pick_wait;
            lat_dly  <= clamped;
        end
    end

endmodule

// File: rtl/sws_fsm.sv
module sws_fsm
    import sws_pkg::*;
#(
    parameter int FW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [FW-1:0] wait_n,
    input  logic [FW-1:0] dly_n,
    output logic          idle,
    output logic          cs_act,
    output logic          we_act,
    output logic          hold
);

    sws_state_e    state;
    sws_state_e    nxt;
    logic [FW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (start) nxt = S_ADDR;
            S_ADDR:  nxt = S_WAIT;
            S_WAIT:  if (cnt == wait_n) nxt = S_HOLD;
            S_HOLD:  nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt <= '0;
        else if (state == S_WAIT)  cnt <= cnt + 1'b1;
        else                       cnt <= '0;
    end

    always_comb begin
        idle   = (state == S_IDLE);
        cs_act = (state != S_IDLE);
        we_act = (state == S_WAIT) && (cnt >= dly_n);
        hold   = (state == S_HOLD);
    end

endmodule

// File: rtl/sws_write_seq.sv
module sws_write_seq
    import sws_pkg::*;
#(
    parameter int BANKS = 4,
    parameter int AW    = 24,
    parameter int DW    = 32,
    parameter int FW    = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       acc_en,
    input  logic                       low_power,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [$clog2(BANKS)-1:0]   req_bank,
    input  logic [AW-1:0]              req_addr,
    input  logic [DW-1:0]              req_data,
    input  logic [DW/8-1:0]            req_be,
    input  logic                       reg_we,
    input  logic [$clog2(BANKS)+4:0]   reg_addr,
    input  logic [31:0]                reg_wdata,
    output logic [31:0]                reg_rdata,
    output logic                       reg_wait,
    output logic [BANKS-1:0]           mem_cs,
    output logic                       mem_we,
    output logic [DW/8-1:0]            mem_be,
    output logic [AW-1:0]              mem_addr,
    output logic [DW-1:0]              mem_dout,
    output logic                       mem_oe,
    output logic                       done
);

    localparam int BW   = DW / 8;
    localparam int BK_W = $clog2(BANKS);

    logic                     idle, cs_act, we_act, hold, fire, commit;
    logic [BANKS-1:0][FW-1:0] dly_all, wait_all;
    logic [BK_W-1:0]          lat_bank;
    logic [AW-1:0]            lat_addr;
    logic [DW-1:0]            lat_data;
    logic [BW-1:0]            lat_be;
    logic [FW-1:0]            lat_wait, lat_dly;

    assign req_ready = idle && acc_en && !low_power;
    assign fire      = req_valid && req_ready;
    assign reg_wait  = !idle || fire;
    assign commit    = reg_we && !reg_wait;

    sws_regs #(.BANKS(BANKS), .FW(FW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (commit),
        .addr    (reg_addr),
        .wr_data (reg_wdata),
        .rd_data (reg_rdata),
        .dly_o   (dly_all),
        .wait_o  (wait_all)
    );

    sws_capture #(.BANKS(BANKS), .AW(AW), .DW(DW), .FW(FW)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (fire),
        .in_bank  (req_bank),
        .in_addr  (req_addr),
        .in_data  (req_data),
        .in_be    (req_be),
        .dly_all  (dly_all),
        .wait_all (wait_all),
        .lat_bank (lat_bank),
        .lat_addr (lat_addr),
        .lat_data (lat_data),
        .lat_be   (lat_be),
        .lat_wait (lat_wait),
        .lat_dly  (lat_dly)
    );

    sws_fsm #(.FW(FW)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (fire),
        .wait_n (lat_wait),
        .dly_n  (lat_dly),
        .idle   (idle),
        .cs_act (cs_act),
        .we_act (we_act),
        .hold   (hold)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_cs
        assign mem_cs[b] = cs_act && (lat_bank == BK_W'(b));
    end

    assign mem_we   = we_act;
    assign mem_be   = we_act ? lat_be : '0;
    assign mem_addr = cs_act ? lat_addr : '0;
    assign mem_dout = cs_act ? lat_data : '0;
    assign mem_oe   = cs_act;
    assign done     = hold;

endmodule

// File: rtl/sws_checker.sv
module sws_checker #(
    parameter int BANKS = 4,
    parameter int AW    = 24,
    parameter int DW    = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_en,
    input logic             low_power,
    input logic             req_valid,
    input logic             req_ready,
    input logic             reg_wait,
    input logic [BANKS-1:0] mem_cs,
    input logic             mem_we,
    input logic [DW/8-1:0]  mem_be,
    input logic [AW-1:0]    mem_addr,
    input logic [DW-1:0]    mem_dout,
    input logic             mem_oe,
    input logic             done
);

    p_cs_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mem_cs));

    p_strobe_in_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_cs != '0));

    p_lanes_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we |-> (mem_be == '0));

    p_held_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_cs != '0) && !done) |=>
            ($stable(mem_addr) && $stable(mem_dout) && $stable(mem_cs) && mem_oe));

    p_strobe_off_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_we);

    p_strobe_ends_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we) |-> done);

    p_done_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ((mem_cs == '0) && !done));

    p_accept_opens_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (mem_cs != '0));

    p_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_en || low_power) |-> !req_ready);

    p_busy_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cs != '0) |-> (reg_wait && !req_ready));

endmodule

bind sws_write_seq sws_checker #(.BANKS(BANKS), .AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_en    (acc_en),
    .low_power (low_power),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .reg_wait  (reg_wait),
    .mem_cs    (mem_cs),
    .mem_we    (mem_we),
    .mem_be    (mem_be),
    .mem_addr  (mem_addr),
    .mem_dout  (mem_dout),
    .mem_oe    (mem_oe),
    .done      (done)
);

// File: tb/test_sws_write_seq.sv
`timescale 1ns/100ps
module test_sws_write_seq;

    logic        clk = 1'b0;
    logic        rst_n, acc_en, low_power, req_valid, reg_we;
    logic [1:0]  req_bank;
    logic [23:0] req_addr;
    logic [31:0] req_data, reg_wdata, reg_rdata;
    logic [3:0]  req_be, mem_be;
    logic [6:0]  reg_addr;
    logic        req_ready, reg_wait, mem_we, mem_oe, done;
    logic [3:0]  mem_cs;
    logic [23:0] mem_addr;
    logic [31:0] mem_dout;

    int          n_run = 0;
    int          n_fail = 0;
    logic [4:0]  mdly  [4];
    logic [4:0]  mwait [4];

    always #2.5 clk = ~clk;

    sws_write_seq i_sws_write_seq (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .low_power(low_power),
        .req_valid(req_valid), .req_ready(req_ready), .req_bank(req_bank),
        .req_addr(req_addr), .req_data(req_data), .req_be(req_be),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_wait(reg_wait), .mem_cs(mem_cs),
        .mem_we(mem_we), .mem_be(mem_be), .mem_addr(mem_addr),
        .mem_dout(mem_dout), .mem_oe(mem_oe), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int eff_dly(input int b);
        return (mdly[b] > mwait[b]) ? int'(mwait[b]) : int'(mdly[b]);
    endfunction

    task automatic reg_write(input int b, input int off, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 7'(b * 32 + off); reg_wdata = v;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
        if (off == 0) mdly[b]  = v[4:0];
        if (off == 4) mwait[b] = v[4:0];
    endtask

    task automatic reg_read(input int b, input int off, output logic [31:0] v);
        @(negedge clk);
        reg_addr = 7'(b * 32 + off);
        #1 v = reg_rdata;
    endtask

    task automatic run_write(input int b, input logic [23:0] a, input logic [31:0] dt,
                             input logic [3:0] be, input bit poke, input logic [4:0] pval);
        int n, d, len, e_cs, e_we, e_be, e_ad, e_dn, e_st;
        logic exp_we;
        n = mwait[b]; d = eff_dly(b);
        len = 0; e_cs = 0; e_we = 0; e_be = 0; e_ad = 0; e_dn = 0; e_st = 0;
        @(negedge clk);
        req_valid = 1'b1; req_bank = 2'(b); req_addr = a; req_data = dt; req_be = be;
        #1 chk(req_ready, "R4", "ready while idle", req_ready, 1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int idx = 0; idx < 40; idx++) begin
            if (idx > 0) @(negedge clk);
            if (mem_cs == 4'b0) break;
            len++;
            exp_we = (idx >= 1 + d) && (idx <= n + 1);
            if (mem_cs != (4'b1 << b)) e_cs++;
            if (mem_we != exp_we) e_we++;
            if (mem_be != (exp_we ? be : 4'b0)) e_be++;
            if (mem_addr != a || mem_dout != dt || !mem_oe) e_ad++;
            if (done != (idx == n + 2)) e_dn++;
            if (!reg_wait || req_ready) e_st++;
            if (poke && idx == 1) begin
                reg_we = 1'b1; reg_addr = 7'(b * 32 + 4); reg_wdata = {27'h0, pval};
            end
        end
        chk(len == n + 3, "R1", "cycle length", len, n + 3);
        chk(e_cs == 0, "R9", "chip select mismatches", e_cs, 0);
        chk(e_we == 0, "R2", "strobe mismatches", e_we, 0);
        chk(e_be == 0, "R10", "lane mismatches", e_be, 0);
        chk(e_ad == 0, "R3", "address/data mismatches", e_ad, 0);
        chk(e_dn == 0, "R4", "done mismatches", e_dn, 0);
        chk(e_st == 0, "R7", "busy stall mismatches", e_st, 0);
        if (poke) begin
            @(posedge clk);
            @(negedge clk);
            reg_we = 1'b0;
            mwait[b] = pval;
        end
    endtask

    initial begin
        #400000;
        n_run++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b0; acc_en = 1'b1; low_power = 1'b0; req_valid = 1'b0; reg_we = 1'b0;
        req_bank = '0; req_addr = '0; req_data = '0; req_be = '0;
        reg_addr = '0; reg_wdata = '0;
        for (int b = 0; b < 4; b++) begin mdly[b] = 5'd0; mwait[b] = 5'd31; end
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R6 reset state
        @(negedge clk);
        chk(mem_cs == 0 && !mem_we && !done && !mem_oe, "R6", "outputs idle",
            {mem_cs, mem_we, done}, 0);
        chk(req_ready, "R6", "ready after reset", req_ready, 1);
        for (int b = 0; b < 4; b++) begin
            reg_read(b, 4, rv); chk(rv == 31, "R6", "wait reset", rv, 31);
            reg_read(b, 0, rv); chk(rv == 0, "R6", "delay reset", rv, 0);
        end

        // R5 field width, reserved bits and unused offsets
        reg_write(1, 4, 32'hFFFF_FFE9);
        reg_read(1, 4, rv); chk(rv == 32'd9, "R5", "wait field masked", rv, 9);
        reg_write(1, 0, 32'hABCD_0003);
        reg_read(1, 0, rv); chk(rv == 32'd3, "R5", "delay field masked", rv, 3);
        reg_write(1, 8, 32'h0000_001F);
        reg_read(1, 8, rv); chk(rv == 0, "R5", "unused offset reads zero", rv, 0);
        reg_read(1, 4, rv); chk(rv == 32'd9, "R5", "unused offset no effect", rv, 9);
        reg_read(0, 4, rv); chk(rv == 32'd31, "R5", "other bank untouched", rv, 31);

        // R1 zero wait states, R2 delay, R2 clamp, maximum
        reg_write(0, 4, 0);
        run_write(0, 24'h00_1234, 32'hDEAD_BEEF, 4'hF, 1'b0, 5'd0);
        run_write(1, 24'h55_AA55, 32'h1234_5678, 4'h5, 1'b0, 5'd0);
        reg_write(2, 4, 2); reg_write(2, 0, 7);
        run_write(2, 24'hFF_0001, 32'hCAFE_F00D, 4'hA, 1'b0, 5'd0);
        reg_write(3, 0, 31);
        run_write(3, 24'h80_0000, 32'h0F0F_0F0F, 4'h3, 1'b0, 5'd0);

        // R7 register write held off during a cycle, then committed
        reg_write(0, 4, 4); reg_write(0, 0, 1);
        run_write(0, 24'h00_0040, 32'h1111_2222, 4'hC, 1'b1, 5'd6);
        reg_read(0, 4, rv); chk(rv == 32'd6, "R7", "held write committed", rv, 6);
        run_write(0, 24'h00_0044, 32'h3333_4444, 4'h1, 1'b0, 5'd0);

        // R8 access blocked
        for (int m = 0; m < 2; m++) begin
            @(negedge clk);
            acc_en = (m == 1); low_power = (m == 1);
            req_valid = 1'b1; req_bank = 2'd2;
            repeat (3) begin
                @(negedge clk);
                chk(!req_ready && mem_cs == 0, "R8", "request blocked",
                    {req_ready, mem_cs}, 0);
            end
            req_valid = 1'b0;
            @(negedge clk);
            acc_en = 1'b1; low_power = 1'b0;
        end

        // random mix
        for (int t = 0; t < 40; t++) begin
            int b;
            b = $urandom_range(0, 3);
            if ($urandom_range(0, 1) == 1) begin
                reg_write(b, 4, $urandom_range(0, 12));
                reg_write(b, 0, $urandom_range(0, 15));
            end
            run_write(b, 24'($urandom), $urandom, 4'($urandom),
                      ($urandom_range(0, 5) == 0), 5'($urandom_range(0, 10)));
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule